// File: doc/BRIEF.md
# Vector Saturating Shift-Right Narrow Unit

This block decodes and executes a single vector instruction. The instruction treats the source vector as a row of unsigned double-width elements. It shifts each element right by an immediate amount and clamps the result to the unsigned range of a half-width lane. The clamped value goes into the even-numbered half-width lane of the destination, and the odd-numbered lane beside it is cleared. One 6-bit immediate in the instruction word carries both the lane width and the shift distance. The position of its leading one selects a narrow lane of 8, 16 or 32 bits, and the remaining bits set the shift.

The caller presents a 32-bit word, a feature-enable bit, the source vector and a one-cycle start strobe. One clock later the block reports one of three outcomes. It either delivers a result, or flags the word as undefined, or reports that the word is not this instruction at all. It also returns the register indices taken from the word. A small two-state controller sequences the response. It moves from ST_IDLE to ST_RESULT on a start strobe, stays in ST_RESULT while strobes keep arriving, and falls back to ST_IDLE on the first cycle without one. Outcome flags are only ever driven from ST_RESULT.

Top module: `svn_unit`

## Requirements
- R1: A word is recognised only when bits 31:23 equal 010001010, bit 21 is 1 and bits 15:10 equal 001100. For any other word, the cycle after start shows `nomatch` high with `res_valid` and `undef` low.
- R2: On every start, `rs_idx` takes word bits 9:5 and `rd_idx` takes word bits 4:0. Both appear the cycle after start.
- R3: The 3-bit size code is {bit 22, bits 20:19}. When it is 000, a recognised word raises `undef` and `res_vec` is all zeros.
- R4: A recognised word with `feat_en` low raises `undef` and returns an all-zero `res_vec`. `res_valid` is high together with `undef` in both undefined cases.
- R5: The narrow lane width is 8 when the size code is 001, 16 when it is 01x and 32 when it is 1xx. Source elements are twice that width.
- R6: The shift equals twice the narrow width minus the 6-bit value {size code, bits 18:16}. This ranges from 1 up to the narrow width, inclusive.
- R7: Each shifted source element is clamped to 2^width − 1 and written to narrow lane 2e.
- R8: Narrow lane 2e+1 of the result is always zero.
- R9: Every source element of the vector is processed, VLEN/(2·width) of them, with no masking.
- R10: Outcome flags pulse for exactly the cycle after each start. With no start the following cycle has `res_valid`, `undef` and `nomatch` all low, including after reset.
- R11: The controller is in ST_RESULT exactly in the cycles that follow a start. Back-to-back starts produce back-to-back outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation strobe, one cycle per word |
| feat_en | input | 1 | Instruction family enabled |
| instr | input | 32 | Instruction word |
| src_vec | input | VLEN | Source vector |
| res_vec | output | VLEN | Destination vector, held until next start |
| rd_idx | output | 5 | Destination register index |
| rs_idx | output | 5 | Source register index |
| undef | output | 1 | Recognised but undefined word |
| nomatch | output | 1 | Word is not this instruction |
| res_valid | output | 1 | Recognised word completed |

## Verification
The bench drives every size code at both shift extremes. A width-selection fault would put values in the wrong lanes. An off-by-one in the shift subtraction would show up as results off by a factor of two at shift 1 or at a shift equal to the width. All-ones sources exceed the clamp limit, so a design that truncates instead of saturating would return wrong low bits. Nonzero bits in the odd source halves would leak into cleared lanes if those lanes were not forced to zero. Size code 000, a low enable, corrupted opcode bits and idle gaps between back-to-back strobes target wrong flag combinations, stale data in undefined results, and outcome pulses that linger.

// File: rtl/svn_pkg.sv
package svn_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } svn_state_e;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_H16 = 2'd1,
        SZ_W32 = 2'd2
    } svn_size_e;

    localparam logic [8:0] OPC_TOP = 9'b010001010;
    localparam logic [5:0] OPC_MID = 6'b001100;
    localparam int         N_SIZES = 3;

    typedef struct packed {
        logic       match;
        logic       undef;
        svn_size_e  size;
        logic [6:0] shamt;
        logic [4:0] rd;
        logic [4:0] rn;
    } svn_dec_t;

endpackage

// File: rtl/svn_decode.sv
module svn_decode
    import svn_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        feat_en,
    output svn_dec_t    dec
);
    logic [2:0] tsz;
    logic [5:0] imm6;
    logic [6:0] dbl_w;

    always_comb begin
        tsz  = {instr[22], instr[20:19]};
        imm6 = {tsz, instr[18:16]};

        dec.match = (instr[31:23] == OPC_TOP) && instr[21] && (instr[15:10] == OPC_MID);
        dec.undef = (tsz == 3'b000) || !feat_en;
        dec.rd    = instr[4:0];
        dec.rn    = instr[9:5];

        if (tsz[2]) begin
            dec.size = SZ_W32;
        end else if (tsz[1]) begin
            dec.size = SZ_H16;
        end else begin
            dec.size = SZ_B8;
        end

        dbl_w     = 7'd16 << dec.size;
        dec.shamt = dbl_w - {1'b0, imm6};
    end
endmodule

// File: rtl/svn_lane.sv
module svn_lane #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] src,
    input  logic [6:0]     sh,
    output logic [W-1:0]   q
);
    logic [2*W-1:0] shr;

    always_comb begin
        shr = src >> sh;
        if (|shr[2*W-1:W]) begin
            q = '1;
        end else begin
            q = shr[W-1:0];
        end
    end
endmodule

// File: rtl/svn_datapath.sv
module svn_datapath
    import svn_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic [VLEN-1:0] src,
    input  svn_size_e       size,
    input  logic [6:0]      sh,
    output logic [VLEN-1:0] res
);
    logic [VLEN-1:0] cand [N_SIZES];

    for (genvar k = 0; k < N_SIZES; k++) begin : g_sz
        localparam int W  = 8 << k;
        localparam int NE = VLEN / (2 * W);
        logic [VLEN-1:0] packed_v;

        for (genvar e = 0; e < NE; e++) begin : g_el
            logic [W-1:0] lane_q;
            svn_lane #(.W(W)) u_lane (
                .src (src[2*W*e +: 2*W]),
                .sh  (sh),
                .q   (lane_q)
            );
            assign packed_v[2*W*e +: W]     = lane_q;
            assign packed_v[2*W*e + W +: W] = '0;
        end
        assign cand[k] = packed_v;
    end

    always_comb begin
        unique case (size)
            SZ_B8:   res = cand[0];
            SZ_H16:  res = cand[1];
            SZ_W32:  res = cand[2];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/svn_unit.sv
module svn_unit
    import svn_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            feat_en,
    input  logic [31:0]     instr,
    input  logic [VLEN-1:0] src_vec,
    output logic [VLEN-1:0] res_vec,
    output logic [4:0]      rd_idx,
    output logic [4:0]      rs_idx,
    output logic            undef,
    output logic            nomatch,
    output logic            res_valid
);
    svn_state_e      state_q, state_d;
    svn_dec_t        dec;
    logic [VLEN-1:0] dp_res;
    logic            match_q, undef_q;

    svn_decode u_dec (
        .instr   (instr),
        .feat_en (feat_en),
        .dec     (dec)
    );

    svn_datapath #(.VLEN(VLEN)) u_dp (
        .src  (src_vec),
        .size (dec.size),
        .sh   (dec.shamt),
        .res  (dp_res)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = start ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            undef_q <= 1'b0;
            res_vec <= '0;
            rd_idx  <= '0;
            rs_idx  <= '0;
        end else if (start) begin
            match_q <= dec.match;
            undef_q <= dec.match && dec.undef;
            rd_idx  <= dec.rd;
            rs_idx  <= dec.rn;
            res_vec <= (dec.match && !dec.undef) ? dp_res : '0;
        end
    end

    always_comb begin
        res_valid = 1'b0;
        undef     = 1'b0;
        nomatch   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_RESULT: begin
                res_valid = match_q;
                undef     = undef_q;
                nomatch   = !match_q;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/svn_unit_chk.sv
module svn_unit_chk #(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [31:0]     instr,
    input logic [VLEN-1:0] res_vec,
    input logic [4:0]      rd_idx,
    input logic [4:0]      rs_idx,
    input logic            undef,
    input logic            nomatch,
    input logic            res_valid
);
    AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, nomatch})); // R1
    AST_INDEX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rd_idx == $past(instr[4:0])) && (rs_idx == $past(instr[9:5]))); // R2
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (res_vec == '0)); // R3
    AST_UNDEF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> res_valid); // R4
    AST_TOP_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_vec[VLEN-1 -: 8] == 8'd0)); // R8
    AST_QUIET_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !res_valid && !undef && !nomatch); // R10
    AST_START_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (res_valid || nomatch)); // R11
endmodule

bind svn_unit svn_unit_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .instr     (instr),
    .res_vec   (res_vec),
    .rd_idx    (rd_idx),
    .rs_idx    (rs_idx),
    .undef     (undef),
    .nomatch   (nomatch),
    .res_valid (res_valid)
);

// File: tb/svn_unit_bench.sv
module svn_unit_bench;
    localparam int VLEN = 128;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            feat_en = 1'b0;
    logic [31:0]     instr = '0;
    logic [VLEN-1:0] src_vec = '0;
    logic [VLEN-1:0] res_vec;
    logic [4:0]      rd_idx, rs_idx;
    logic            undef, nomatch, res_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        bit              st;
        bit              v;
        bit              u;
        bit              nm;
        logic [VLEN-1:0] vec;
        logic [4:0]      rd;
        logic [4:0]      rs;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    svn_unit #(.VLEN(VLEN)) u_svn_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .feat_en(feat_en),
        .instr(instr), .src_vec(src_vec), .res_vec(res_vec),
        .rd_idx(rd_idx), .rs_idx(rs_idx), .undef(undef),
        .nomatch(nomatch), .res_valid(res_valid)
    );

    task automatic chk(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int tsz, int imm3, int rn, int rd);
        logic [2:0] t = 3'(tsz);
        return {9'b010001010, t[2], 1'b1, t[1:0], 3'(imm3), 6'b001100, 5'(rn), 5'(rd)};
    endfunction

    function automatic exp_t model(bit st, logic [31:0] w, bit fe, logic [VLEN-1:0] s);
        exp_t r;
        int ts, esz, sh;
        longint unsigned m2, lim, el, rv;
        logic [VLEN-1:0] tmp;
        r.st = st; r.v = 0; r.u = 0; r.nm = 0; r.vec = '0;
        r.rd = w[4:0]; r.rs = w[9:5];
        if (!st) return r;
        if (!((w[31:23] == 9'b010001010) && w[21] && (w[15:10] == 6'b001100))) begin
            r.nm = 1;
            return r;
        end
        r.v = 1;
        ts = int'({w[22], w[20:19]});
        if (ts == 0 || !fe) begin
            r.u = 1;
            return r;
        end
        esz = (ts >= 4) ? 32 : (ts >= 2) ? 16 : 8;
        sh  = 2 * esz - (ts * 8 + int'(w[18:16]));
        m2  = (esz == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * esz)) - 1);
        lim = (64'd1 << esz) - 1;
        for (int e = 0; e < VLEN / (2 * esz); e++) begin
            tmp = s >> (e * 2 * esz);
            el  = tmp[63:0] & m2;
            rv  = el >> sh;
            if (rv > lim) rv = lim;
            r.vec = r.vec | ({{(VLEN-64){1'b0}}, rv} << (2 * e * esz));
        end
        return r;
    endfunction

    task automatic compare();
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        chk("R1 R10 R11 res_valid", res_valid, e.v);
        chk("R3 R4 R10 undef", undef, e.u);
        chk("R1 R10 nomatch", nomatch, e.nm);
        if (e.st) begin
            chk("R2 rd_idx", rd_idx, e.rd);
            chk("R2 rs_idx", rs_idx, e.rs);
            if (e.u || e.nm) chk("R3 R4 zero vector", res_vec, e.vec);
            else chk("R5 R6 R7 R8 R9 result", res_vec, e.vec);
        end
    endtask

    task automatic step(bit st, logic [31:0] w, bit fe, logic [VLEN-1:0] s);
        @(negedge clk);
        compare();
        start = st; instr = w; feat_en = fe; src_vec = s;
        q.push_back(model(st, w, fe, s));
    endtask

    function automatic logic [VLEN-1:0] rvec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog R10 act=hung exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t z;
        logic [VLEN-1:0] ones, alt;
        ones = '1;
        for (int i = 0; i < VLEN / 8; i++) alt[8*i +: 8] = 8'(8'hA5 + 8'(i * 37));
        repeat (3) @(negedge clk);
        chk("R10 reset res_valid", res_valid, 1'b0);
        chk("R10 reset undef", undef, 1'b0);
        chk("R10 reset nomatch", nomatch, 1'b0);
        rst_n = 1'b1;
        z = model(0, '0, 0, '0);
        q.push_back(z);
        // R5 R6 R7: every size code at both shift extremes, saturating and patterned inputs
        for (int ts = 1; ts < 8; ts++) begin
            for (int im = 0; im < 8; im += 7) begin
                step(1, mk(ts, im, ts, im + 3), 1, ones);
                step(1, mk(ts, im, 31 - ts, im), 1, alt);
                step(0, '0, 1, '0);
            end
        end
        // R8: odd halves carry data that must be cleared
        step(1, mk(1, 7, 1, 2), 1, alt);
        // R3 size code zero, R4 feature off
        step(1, mk(0, 5, 7, 9), 1, alt);
        step(1, mk(4, 0, 3, 4), 0, alt);
        // R1: corrupted opcode bits
        step(1, mk(4, 0, 3, 4) ^ 32'h8000_0000, 1, alt);
        step(1, mk(2, 1, 3, 4) & ~32'h0020_0000, 1, alt);
        step(1, mk(2, 1, 3, 4) ^ 32'h0000_0400, 1, alt);
        step(0, '0, 1, '0);
        // R9 R11: random mix with gaps
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            int ts;
            ts = int'($urandom_range(0, 7));
            w = mk(ts, int'($urandom_range(0, 7)), int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
            if ($urandom_range(0, 9) == 0) w = w ^ (32'd1 << $urandom_range(10, 31));
            step($urandom_range(0, 3) != 0, w, $urandom_range(0, 7) != 0,
                 ($urandom_range(0, 3) == 0) ? ones : rvec());
        end
        step(0, '0, 1, '0);
        step(0, '0, 1, '0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule